// File: doc/BRIEF.md
# Binary Trie Route Lookup Engine

This block maps a 32-bit IPv4 destination address to a next-hop code by walking a binary trie kept in an on-chip node memory. The walk starts at node 0, which is the root. Each step consumes one address bit, most significant bit first. The engine remembers the next hop of the deepest visited node that carries a prefix, so it returns the longest matching prefix. When the walk visits no prefix node, the engine returns a configured default next hop.

Before any walk starts, the address is compared in parallel against a small table of the router's own addresses. On a hit, the node memory is never read and the result is marked local. Only one lookup is in flight at a time. A configuration port writes trie nodes, local-table entries and the default next hop. It accepts writes only while the engine is idle.

Top module: `trie_lookup_engine`

## Requirements
- R1: The walk starts at node 0 and consumes the address from bit 31 downward. A 0 bit follows the left child and a 1 bit follows the right child.
- R2: The result next hop is the one held by the deepest visited node whose prefix-present bit is set, and res_default is 0.
- R3: If no visited node carries a prefix, res_nh equals the configured default next hop and res_default is 1.
- R4: An address that equals a valid local-table entry gives res_local=1, res_nh=0 and res_default=0. The trie is not walked, and res_valid rises 2 clock edges after the accepting edge.
- R5: The local table has 4 entries, each written with an address and a valid bit. An entry whose valid bit is 0 never matches.
- R6: The walk stops at a node whose selected child-valid bit is 0.
- R7: A walk that consumes d address bits (0 to 32) raises res_valid 3+2d edges after the accepting edge. The walk never consumes more than 32 bits, so the worst case is 67 edges.
- R8: req_ready is low from acceptance until the result handshake (res_valid and res_ready) completes. The result outputs stay stable while res_valid waits for res_ready.
- R9: Configuration writes made while the engine is busy (cfg_ready low) have no effect.
- R10: The node word is 23 bits. Bit 22 is prefix-present, bits 21:14 are the next hop, bit 13 is right-valid, bits 12:7 are the right pointer, bit 6 is left-valid and bits 5:0 are the left pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Engine can accept a request |
| req_addr | input | 32 | Destination address |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Result consumed |
| res_nh | output | 8 | Next hop |
| res_local | output | 1 | Address belongs to the router |
| res_default | output | 1 | Default route was used |
| cfg_ready | output | 1 | Configuration writes are accepted |
| cfg_node_we | input | 1 | Node write strobe |
| cfg_node_idx | input | 6 | Node index |
| cfg_node_word | input | 23 | Node word (layout in R10) |
| cfg_local_we | input | 1 | Local entry write strobe |
| cfg_local_idx | input | 2 | Local entry index |
| cfg_local_valid | input | 1 | Local entry valid bit |
| cfg_local_addr | input | 32 | Local entry address |
| cfg_dflt_we | input | 1 | Default next-hop write strobe |
| cfg_dflt_nh | input | 8 | Default next hop |

## Verification
The assertions take for granted that every node a walk can reach was written beforehand. Node memory has no reset, so a read of an unwritten node gives undefined pointers. The stimulus writes each trie completely before issuing lookups that travel through it. All stimulus is driven on the falling edge, so no request or configuration write is ever seen half-changed at a rising edge.

// File: rtl/trie_pkg.sv
package trie_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LCHK,
        ST_READ,
        ST_EVAL,
        ST_DONE
    } walk_st_e;
endpackage

// File: rtl/trie_node_ram.sv
module trie_node_ram #(
    parameter int DEPTH_LOG2 = 6,
    parameter int WORD_W     = 23
) (
    input  logic                  clk,
    input  logic                  wr_en,
    input  logic [DEPTH_LOG2-1:0] wr_addr,
    input  logic [WORD_W-1:0]     wr_data,
    input  logic                  rd_en,
    input  logic [DEPTH_LOG2-1:0] rd_addr,
    output logic [WORD_W-1:0]     rd_data
);
    localparam int ENTRIES = 1 << DEPTH_LOG2;

    logic [WORD_W-1:0] mem_q [ENTRIES];

    always_ff @(posedge clk) begin
        if (wr_en) mem_q[wr_addr] <= wr_data;
        if (rd_en) rd_data <= mem_q[rd_addr];
    end
endmodule

// File: rtl/local_addr_match.sv
module local_addr_match #(
    parameter int ADDR_W  = 32,
    parameter int ENTRIES = 4,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [ADDR_W-1:0] probe_addr,
    output logic              hit
);
    logic [ADDR_W-1:0]  tab_q [ENTRIES];
    logic [ENTRIES-1:0] val_q;
    logic [ENTRIES-1:0] hit_vec;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                val_q[i] <= 1'b0;
                tab_q[i] <= '0;
            end else if (wr_en && wr_idx == IDX_W'(i)) begin
                val_q[i] <= wr_valid;
                tab_q[i] <= wr_addr;
            end
        end
        assign hit_vec[i] = val_q[i] && (tab_q[i] == probe_addr);
    end

    assign hit = |hit_vec;

    // R5: a match is only possible when some entry is marked valid
    p_hit_needs_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (val_q != '0));
endmodule

// File: rtl/trie_lookup_engine.sv
module trie_lookup_engine
    import trie_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int PTR_W   = 6,
    parameter int NH_W    = 8,
    parameter int LOCAL_N = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    output logic                       req_ready,
    input  logic [ADDR_W-1:0]          req_addr,
    output logic                       res_valid,
    input  logic                       res_ready,
    output logic [NH_W-1:0]            res_nh,
    output logic                       res_local,
    output logic                       res_default,
    output logic                       cfg_ready,
    input  logic                       cfg_node_we,
    input  logic [PTR_W-1:0]           cfg_node_idx,
    input  logic [2*PTR_W+NH_W+2:0]    cfg_node_word,
    input  logic                       cfg_local_we,
    input  logic [$clog2(LOCAL_N)-1:0] cfg_local_idx,
    input  logic                       cfg_local_valid,
    input  logic [ADDR_W-1:0]          cfg_local_addr,
    input  logic                       cfg_dflt_we,
    input  logic [NH_W-1:0]            cfg_dflt_nh
);
    localparam int NODE_W  = 2 * PTR_W + NH_W + 3;
    localparam int DEPTH_W = $clog2(ADDR_W + 1);
    localparam int MAX_LAT = 2 * ADDR_W + 3;
    localparam int LAT_W   = $clog2(MAX_LAT + 2);

    typedef struct packed {
        logic             has_pfx;
        logic [NH_W-1:0]  nh;
        logic             r_ok;
        logic [PTR_W-1:0] r_ptr;
        logic             l_ok;
        logic [PTR_W-1:0] l_ptr;
    } node_t;

    typedef struct packed {
        walk_st_e           st;
        logic [ADDR_W-1:0]  addr;
        logic [DEPTH_W-1:0] depth;
        logic [PTR_W-1:0]   ptr;
        logic [NH_W-1:0]    best;
        logic               found;
        logic [NH_W-1:0]    dflt;
        logic [NH_W-1:0]    r_nh;
        logic               r_local;
        logic               r_dflt;
    } regs_t;

    regs_t             d, q;
    logic              idle;
    logic              rd_en;
    logic [PTR_W-1:0]  rd_addr;
    logic [NODE_W-1:0] rd_word;
    logic              local_hit;

    assign idle = (q.st == ST_IDLE);

    trie_node_ram #(.DEPTH_LOG2(PTR_W), .WORD_W(NODE_W)) u_ram (
        .clk     (clk),
        .wr_en   (cfg_node_we && idle),
        .wr_addr (cfg_node_idx),
        .wr_data (cfg_node_word),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .rd_data (rd_word)
    );

    local_addr_match #(.ADDR_W(ADDR_W), .ENTRIES(LOCAL_N)) u_local (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (cfg_local_we && idle),
        .wr_idx     (cfg_local_idx),
        .wr_valid   (cfg_local_valid),
        .wr_addr    (cfg_local_addr),
        .probe_addr (q.addr),
        .hit        (local_hit)
    );

    always_comb begin
        node_t            node;
        logic             found_n;
        logic [NH_W-1:0]  best_n;
        logic             child_ok;
        logic [PTR_W-1:0] child;

        d        = q;
        rd_en    = 1'b0;
        rd_addr  = q.ptr;
        node     = node_t'(rd_word);
        found_n  = q.found || node.has_pfx;
        best_n   = node.has_pfx ? node.nh : q.best;
        child_ok = q.addr[ADDR_W-1] ? node.r_ok  : node.l_ok;
        child    = q.addr[ADDR_W-1] ? node.r_ptr : node.l_ptr;

        if (cfg_dflt_we && idle) d.dflt = cfg_dflt_nh;

        case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.st   = ST_LCHK;
                    d.addr = req_addr;
                end
            end
            ST_LCHK: begin
                if (local_hit) begin
                    d.r_nh    = '0;
                    d.r_local = 1'b1;
                    d.r_dflt  = 1'b0;
                    d.st      = ST_DONE;
                end else begin
                    rd_en   = 1'b1;
                    rd_addr = '0;
                    d.depth = '0;
                    d.found = 1'b0;
                    d.best  = '0;
                    d.st    = ST_EVAL;
                end
            end
            ST_READ: begin
                rd_en = 1'b1;
                d.st  = ST_EVAL;
            end
            ST_EVAL: begin
                if (q.depth != DEPTH_W'(ADDR_W) && child_ok) begin
                    d.ptr   = child;
                    d.depth = q.depth + 1'b1;
                    d.addr  = q.addr << 1;
                    d.found = found_n;
                    d.best  = best_n;
                    d.st    = ST_READ;
                end else begin
                    d.r_nh    = found_n ? best_n : q.dflt;
                    d.r_local = 1'b0;
                    d.r_dflt  = !found_n;
                    d.st      = ST_DONE;
                end
            end
            ST_DONE: begin
                if (res_ready) d.st = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign req_ready   = idle;
    assign cfg_ready   = idle;
    assign res_valid   = (q.st == ST_DONE);
    assign res_nh      = q.r_nh;
    assign res_local   = q.r_local;
    assign res_default = q.r_dflt;

    // Edge counter since acceptance, used only by the checks below
    logic [LAT_W-1:0] lat_q;
    always_ff @(posedge clk) begin
        if (!rst_n) lat_q <= '0;
        else if (req_valid && req_ready) lat_q <= LAT_W'(1);
        else if (q.st != ST_IDLE && q.st != ST_DONE) lat_q <= lat_q + 1'b1;
    end

    p_latency_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(res_valid) |-> lat_q <= LAT_W'(MAX_LAT));
    p_depth_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        q.depth <= DEPTH_W'(ADDR_W));
    p_local_fast_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(res_valid) && res_local) |-> (lat_q == LAT_W'(2) && !res_default));
    p_one_in_flight_r8: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> !req_ready);
    p_hold_result_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_ready) |=> (res_valid && $stable(res_nh)
                                       && $stable(res_local) && $stable(res_default)));
    p_no_cfg_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_ready && cfg_dflt_we) |=> $stable(q.dflt));
endmodule

// File: tb/trie_lookup_engine_test.sv
`timescale 1ns/1ps
module trie_lookup_engine_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic        res_valid;
    logic        res_ready = 1'b0;
    logic [7:0]  res_nh;
    logic        res_local;
    logic        res_default;
    logic        cfg_ready;
    logic        cfg_node_we = 1'b0;
    logic [5:0]  cfg_node_idx = '0;
    logic [22:0] cfg_node_word = '0;
    logic        cfg_local_we = 1'b0;
    logic [1:0]  cfg_local_idx = '0;
    logic        cfg_local_valid = 1'b0;
    logic [31:0] cfg_local_addr = '0;
    logic        cfg_dflt_we = 1'b0;
    logic [7:0]  cfg_dflt_nh = '0;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    trie_lookup_engine uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .res_valid(res_valid), .res_ready(res_ready), .res_nh(res_nh),
        .res_local(res_local), .res_default(res_default), .cfg_ready(cfg_ready),
        .cfg_node_we(cfg_node_we), .cfg_node_idx(cfg_node_idx), .cfg_node_word(cfg_node_word),
        .cfg_local_we(cfg_local_we), .cfg_local_idx(cfg_local_idx),
        .cfg_local_valid(cfg_local_valid), .cfg_local_addr(cfg_local_addr),
        .cfg_dflt_we(cfg_dflt_we), .cfg_dflt_nh(cfg_dflt_nh)
    );

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // R10 layout: [22] pfx, [21:14] nh, [13] r_ok, [12:7] r_ptr, [6] l_ok, [5:0] l_ptr
    task automatic wr_node(int idx, bit l_ok, int l_ptr, bit r_ok, int r_ptr, bit pfx, int nh);
        @(negedge clk);
        cfg_node_we   = 1'b1;
        cfg_node_idx  = 6'(idx);
        cfg_node_word = {pfx, 8'(nh), r_ok, 6'(r_ptr), l_ok, 6'(l_ptr)};
        @(negedge clk);
        cfg_node_we = 1'b0;
    endtask

    task automatic wr_local(int idx, bit vld, logic [31:0] a);
        @(negedge clk);
        cfg_local_we = 1'b1; cfg_local_idx = 2'(idx);
        cfg_local_valid = vld; cfg_local_addr = a;
        @(negedge clk);
        cfg_local_we = 1'b0;
    endtask

    task automatic wr_dflt(int nh);
        @(negedge clk);
        cfg_dflt_we = 1'b1; cfg_dflt_nh = 8'(nh);
        @(negedge clk);
        cfg_dflt_we = 1'b0;
    endtask

    // One lookup: checks latency, ready gating, hold behaviour and the result
    task automatic lookup(string tag, logic [31:0] a, int e_nh, bit e_loc, bit e_def, int e_lat);
        int lat;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        check({tag, " R8 ready low after accept"}, int'(req_ready), 0);
        while (!res_valid && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        check({tag, " R7 latency"}, lat, e_lat);
        check({tag, " nh"}, int'(res_nh), e_nh);
        check({tag, " R4 local flag"}, int'(res_local), int'(e_loc));
        check({tag, " R3 default flag"}, int'(res_default), int'(e_def));
        @(negedge clk);
        check({tag, " R8 result held"}, int'(res_valid && res_nh == 8'(e_nh)), 1);
        res_ready = 1'b1;
        @(negedge clk);
        res_ready = 1'b0;
        check({tag, " R8 ready back"}, int'(req_ready && !res_valid), 1);
    endtask

    task automatic t_reset();
        check("R8 reset req_ready", int'(req_ready), 1);
        check("R8 reset res_valid", int'(res_valid), 0);
        check("R9 reset cfg_ready", int'(cfg_ready), 1);
    endtask

    task automatic t_basic_trie();
        wr_dflt(8'hD0);
        wr_node(0, 1, 1, 0, 0, 0, 0);
        wr_node(1, 0, 0, 1, 2, 1, 8'h11);
        wr_node(2, 1, 3, 0, 0, 1, 8'h22);
        wr_node(3, 0, 0, 0, 0, 0, 0);
        lookup("R1 R2 path 010", 32'h4000_0000, 8'h22, 0, 0, 9);
        lookup("R6 stop at invalid child", 32'h0000_0000, 8'h11, 0, 0, 5);
        lookup("R3 miss at root", 32'h8000_0000, 8'hD0, 0, 1, 3);
    endtask

    task automatic t_local();
        wr_local(2, 1, 32'h4000_0000);
        lookup("R4 local hit", 32'h4000_0000, 0, 1, 0, 2);
        wr_local(3, 0, 32'h0000_0000);
        lookup("R5 invalid entry ignored", 32'h0000_0000, 8'h11, 0, 0, 5);
        wr_local(2, 0, 32'h4000_0000);
        lookup("R5 cleared entry", 32'h4000_0000, 8'h22, 0, 0, 9);
    endtask

    task automatic t_busy_cfg();
        @(negedge clk);
        req_valid = 1'b1; req_addr = 32'h8000_0000;
        @(negedge clk);
        req_valid = 1'b0;
        check("R9 cfg_ready low while busy", int'(cfg_ready), 0);
        cfg_dflt_we = 1'b1; cfg_dflt_nh = 8'h99;
        cfg_local_we = 1'b1; cfg_local_idx = 2'd0;
        cfg_local_valid = 1'b1; cfg_local_addr = 32'h8000_0000;
        @(negedge clk);
        cfg_dflt_we = 1'b0; cfg_local_we = 1'b0;
        while (!res_valid) @(negedge clk);
        res_ready = 1'b1;
        @(negedge clk);
        res_ready = 1'b0;
        lookup("R9 busy writes dropped", 32'h8000_0000, 8'hD0, 0, 1, 3);
    endtask

    task automatic t_deep();
        wr_node(0, 1, 1, 1, 10, 0, 0);
        for (int k = 10; k < 41; k++)
            wr_node(k, 0, 0, 1, k + 1, (k == 20), 8'h55);
        wr_node(41, 0, 0, 1, 41, 1, 8'h77);
        lookup("R7 worst case 32 bits", 32'hFFFF_FFFF, 8'h77, 0, 0, 67);
        lookup("R2 deepest earlier prefix", 32'hFFFF_FFFE, 8'h55, 0, 0, 65);
        lookup("R1 left side intact", 32'h4000_0000, 8'h22, 0, 0, 9);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic_trie();
        t_local();
        t_busy_cfg();
        t_deep();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R7 watchdog act=hung exp=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule